// File: doc/BRIEF.md
# Converter Self-Calibration Trigger Sequencer

This block decides when a data converter's self-calibration runs. After a synchronous reset it waits a power-supply settling interval before the first calibration. The interval is short or long as picked by a select input. A mode input forces the short interval, and a power-down input freezes the count while it is high. When the interval ends, a power-on calibration runs as two consecutive phases: a termination-resistor phase, then a converter phase. Each phase lasts a fixed number of cycles.

Later calibrations are started from a request pin. The pin must be seen low for a minimum number of consecutive cycles and then high for a minimum number of consecutive cycles. Shorter pulses are discarded as noise. An on-command calibration runs only the converter phase. If the request pin is high at power-up, the power-on calibration is skipped, and the first calibration waits for a qualified request. A busy output covers every calibration, a two-bit one-hot phase strobe marks the active phase, and a hold-in-power-down request keeps the analog side asleep until the first calibration finishes or is skipped. All timing counts input clock cycles.

Top module: `adc_cal_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, busy is 0, cal_phase is 2'b00 and hold_pd is 1.
- R2: With ext_ctrl_mode low and pwr_down_in low, busy first rises SHORT_DLY clock edges after reset release when dly_long_sel is 0, and LONG_DLY edges after release when dly_long_sel is 1.
- R3: With ext_ctrl_mode high, dly_long_sel is ignored and busy first rises SHORT_DLY edges after reset release.
- R4: Each clock edge that samples pwr_down_in high during the settling interval adds one edge to the time before busy rises.
- R5: A power-on calibration drives cal_phase to 2'b01 (termination phase) for TERM_LEN cycles and then to 2'b10 (converter phase) for CONV_LEN cycles. busy is high exactly while cal_phase is nonzero, and cal_phase never has both bits set.
- R6: If cal_req_pin is high on the last reset cycle, no power-on calibration runs, hold_pd follows pwr_down_in from the first cycle after reset, and no calibration starts until the pin has been low for at least LOW_MIN cycles followed by a qualified high.
- R7: After the pin has been low for at least LOW_MIN consecutive sampled cycles, busy rises at the HIGH_MIN-th consecutive edge sampling it high. The run that follows holds cal_phase at 2'b10 for CONV_LEN cycles and never enters the termination phase.
- R8: A low stretch shorter than LOW_MIN, or a high stretch shorter than HIGH_MIN, starts no calibration. A low cycle during the high count discards the earlier low qualification, so the low count starts again.
- R9: Request pin activity while busy is high, or during the settling interval, has no effect. After busy falls, both qualification counts restart from zero.
- R10: hold_pd stays 1 until the first calibration completes or is skipped. From then on it equals pwr_down_in delayed by one cycle, and the termination phase never runs while hold_pd is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all timing counts its rising edges |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| dly_long_sel | input | 1 | 1 selects the long settling delay, 0 the short one |
| ext_ctrl_mode | input | 1 | 1 forces the short settling delay |
| pwr_down_in | input | 1 | External power-down; freezes the settling count |
| cal_req_pin | input | 1 | Calibration request pin, low-then-high qualified |
| busy | output | 1 | High for the whole of any calibration |
| cal_phase | output | 2 | One-hot phase strobe: bit 0 termination, bit 1 converter |
| hold_pd | output | 1 | Hold-in-power-down request, merged with pwr_down_in |

## Verification
The bench measures the settling interval for both select values, with the mode override and with power-down held for a known number of cycles. A design that sampled the select in extended mode, or let the count run during power-down, starts calibration on the wrong edge. Request sequences sit exactly on and one cycle under each qualification minimum, including a high stretch broken by a single low cycle. An off-by-one counter, or a qualifier that keeps a stale low qualification, would start a calibration that should be rejected. The bench also drives a full request while busy is high and a request held high from reset. It checks that neither starts a run, and that on-command runs never show the termination phase.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_TERM   = 2'd1,
    ST_CONV   = 2'd2,
    ST_IDLE   = 2'd3
  } cal_state_e;

  localparam int PHASE_W = 2;
  localparam int PH_TERM_BIT = 0;
  localparam int PH_CONV_BIT = 1;

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SHORT_DLY = 4096,
  parameter int LONG_DLY  = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic freeze,
  input  logic use_long,
  output logic done
);
  localparam int CW = $clog2(LONG_DLY + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_DLY - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_DLY - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = use_long ? LONG_LAST : SHORT_LAST;
  assign done = active && !freeze && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt <= '0;
    end else if (!freeze && !done) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int TERM_LEN = 256,
  parameter int CONV_LEN = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run_term,
  input  logic run_conv,
  output logic done
);
  localparam int MAXLEN = (TERM_LEN > CONV_LEN) ? TERM_LEN : CONV_LEN;
  localparam int CW = $clog2(MAXLEN + 1);
  localparam logic [CW-1:0] TERM_LAST = CW'(TERM_LEN - 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_LEN - 1);

  logic [CW-1:0] cnt;

  always_comb begin
    done = 1'b0;
    if (run_term) done = (cnt == TERM_LAST);
    else if (run_conv) done = (cnt == CONV_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst || done || !(run_term || run_conv)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/req_qualifier.sv
module req_qualifier #(
  parameter int LOW_MIN  = 128,
  parameter int HIGH_MIN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic pin,
  output logic fire
);
  localparam int LW = $clog2(LOW_MIN + 1);
  localparam int HW = $clog2(HIGH_MIN + 1);
  localparam logic [LW-1:0] LOW_FULL  = LW'(LOW_MIN);
  localparam logic [HW-1:0] HIGH_LAST = HW'(HIGH_MIN - 1);

  logic [LW-1:0] low_cnt;
  logic [HW-1:0] high_cnt;
  logic          low_ok;

  assign low_ok = (low_cnt == LOW_FULL);
  assign fire   = enable && pin && low_ok && (high_cnt == HIGH_LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable || fire) begin
      low_cnt  <= '0;
      high_cnt <= '0;
    end else if (!pin) begin
      high_cnt <= '0;
      if (high_cnt != '0) begin
        // a broken high stretch: this low cycle starts a fresh low count
        low_cnt <= LW'(1);
      end else if (!low_ok) begin
        low_cnt <= low_cnt + 1'b1;
      end
    end else begin
      if (low_ok) begin
        high_cnt <= high_cnt + 1'b1;
      end else begin
        low_cnt  <= '0;
        high_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
  import adc_cal_pkg::*;
#(
  parameter int SHORT_DLY = 4096,
  parameter int LONG_DLY  = 65536,
  parameter int LOW_MIN   = 128,
  parameter int HIGH_MIN  = 128,
  parameter int TERM_LEN  = 256,
  parameter int CONV_LEN  = 1024
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dly_long_sel,
  input  logic                ext_ctrl_mode,
  input  logic                pwr_down_in,
  input  logic                cal_req_pin,
  output logic                busy,
  output logic [PHASE_W-1:0]  cal_phase,
  output logic                hold_pd
);

  cal_state_e state, state_nxt;
  logic       req_at_rst;
  logic       hold_flag, hold_flag_nxt;
  logic       settle_done, phase_done, req_fire;

  settle_timer #(
    .SHORT_DLY (SHORT_DLY),
    .LONG_DLY  (LONG_DLY)
  ) u_settle (
    .clk      (clk),
    .rst      (rst),
    .active   (state == ST_SETTLE),
    .freeze   (pwr_down_in),
    .use_long (dly_long_sel && !ext_ctrl_mode),
    .done     (settle_done)
  );

  phase_timer #(
    .TERM_LEN (TERM_LEN),
    .CONV_LEN (CONV_LEN)
  ) u_phase (
    .clk      (clk),
    .rst      (rst),
    .run_term (state == ST_TERM),
    .run_conv (state == ST_CONV),
    .done     (phase_done)
  );

  req_qualifier #(
    .LOW_MIN  (LOW_MIN),
    .HIGH_MIN (HIGH_MIN)
  ) u_req (
    .clk    (clk),
    .rst    (rst),
    .enable (state == ST_IDLE),
    .pin    (cal_req_pin),
    .fire   (req_fire)
  );

  always_comb begin
    state_nxt     = state;
    hold_flag_nxt = hold_flag;
    case (state)
      ST_SETTLE: begin
        if (req_at_rst) begin
          state_nxt     = ST_IDLE;
          hold_flag_nxt = 1'b0;
        end else if (settle_done) begin
          state_nxt = ST_TERM;
        end
      end
      ST_TERM: if (phase_done) state_nxt = ST_CONV;
      ST_CONV: begin
        if (phase_done) begin
          state_nxt     = ST_IDLE;
          hold_flag_nxt = 1'b0;
        end
      end
      ST_IDLE: if (req_fire) state_nxt = ST_CONV;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SETTLE;
      req_at_rst <= cal_req_pin;
      hold_flag  <= 1'b1;
      busy       <= 1'b0;
      cal_phase  <= '0;
      hold_pd    <= 1'b1;
    end else begin
      state                  <= state_nxt;
      hold_flag              <= hold_flag_nxt;
      busy                   <= (state_nxt == ST_TERM) || (state_nxt == ST_CONV);
      cal_phase[PH_TERM_BIT] <= (state_nxt == ST_TERM);
      cal_phase[PH_CONV_BIT] <= (state_nxt == ST_CONV);
      hold_pd                <= hold_flag_nxt || pwr_down_in;
    end
  end
endmodule

// File: rtl/adc_cal_seq_chk.sv
module adc_cal_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_down_in,
  input logic       busy,
  input logic [1:0] cal_phase,
  input logic       hold_pd
);
  // R5: phase strobe is one-hot or idle
  p_phase_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cal_phase));

  // R5: any active phase implies busy, and busy implies an active phase
  p_phase_busy_r5: assert property (@(posedge clk) disable iff (rst)
    busy == (cal_phase != 2'b00));

  // R5: the termination phase is always followed by the converter phase
  p_term_then_conv_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(cal_phase[0]) && !cal_phase[0]) |-> cal_phase[1]);

  // R10: external power-down always reaches the hold request next cycle
  p_pd_forwarded_r10: assert property (@(posedge clk) disable iff (rst)
    pwr_down_in |=> hold_pd);

  // R10: the termination phase only runs while the hold request is up
  p_no_term_released_r10: assert property (@(posedge clk) disable iff (rst)
    !hold_pd |-> !cal_phase[0]);

  // R7: the converter phase begins with busy already set
  p_conv_busy_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_phase[1]) |-> busy);
endmodule

bind adc_cal_seq adc_cal_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .pwr_down_in (pwr_down_in),
  .busy        (busy),
  .cal_phase   (cal_phase),
  .hold_pd     (hold_pd)
);

// File: tb/adc_cal_seq_tb.sv
module adc_cal_seq_tb;
  localparam int SHORT_DLY = 20;
  localparam int LONG_DLY  = 50;
  localparam int LOW_MIN   = 6;
  localparam int HIGH_MIN  = 5;
  localparam int TERM_LEN  = 8;
  localparam int CONV_LEN  = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dly_long_sel = 1'b0;
  logic       ext_ctrl_mode = 1'b0;
  logic       pwr_down_in = 1'b0;
  logic       cal_req_pin = 1'b0;
  logic       busy;
  logic [1:0] cal_phase;
  logic       hold_pd;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  adc_cal_seq #(
    .SHORT_DLY (SHORT_DLY), .LONG_DLY (LONG_DLY),
    .LOW_MIN   (LOW_MIN),   .HIGH_MIN (HIGH_MIN),
    .TERM_LEN  (TERM_LEN),  .CONV_LEN (CONV_LEN)
  ) u_dut (
    .clk (clk), .rst (rst), .dly_long_sel (dly_long_sel),
    .ext_ctrl_mode (ext_ctrl_mode), .pwr_down_in (pwr_down_in),
    .cal_req_pin (cal_req_pin), .busy (busy), .cal_phase (cal_phase),
    .hold_pd (hold_pd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic sel, input logic ext, input logic pd, input logic req);
    @(negedge clk);
    rst = 1'b1; dly_long_sel = sel; ext_ctrl_mode = ext;
    pwr_down_in = pd; cal_req_pin = req;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // counts negedges until busy is seen high; drops power-down after pd_cyc
  task automatic wait_busy(output int n, input int limit, input int pd_cyc);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == pd_cyc) pwr_down_in = 1'b0;
    end while (!busy && n < limit);
  endtask

  // called at the negedge where busy was first seen
  task automatic check_phases(input string tag, input bit with_term);
    int t = 0;
    int c = 0;
    if (with_term) begin
      chk({tag, " R5 term phase first"}, cal_phase, 1);
      t = 1;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (cal_phase != 2'b01) break;
        t++;
      end
      chk({tag, " R5 term length"}, t, TERM_LEN);
    end
    chk({tag, " R5/R7 conv phase"}, cal_phase, 2);
    c = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (cal_phase != 2'b10) break;
      c++;
    end
    chk({tag, " R5/R7 conv length"}, c, CONV_LEN);
    chk({tag, " R5 busy low after run"}, busy, 0);
    chk({tag, " R5 phase idle after run"}, cal_phase, 0);
  endtask

  task automatic no_busy_for(input string tag, input int cyc);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (busy) seen = 1;
    end
    chk(tag, seen, 0);
  endtask

  task automatic qualified_request(output int n);
    cal_req_pin = 1'b0;
    repeat (LOW_MIN) @(negedge clk);
    cal_req_pin = 1'b1;
    wait_busy(n, 200, 0);
  endtask

  task automatic t_reset_state();
    do_reset(0, 0, 0, 0);
    chk("R1 busy in reset", busy, 0);
    chk("R1 phase in reset", cal_phase, 0);
    chk("R1 hold_pd in reset", hold_pd, 1);
    @(negedge clk);
    chk("R1 busy after release", busy, 0);
    chk("R1 hold_pd after release", hold_pd, 1);
  endtask

  task automatic t_por_short();
    int n;
    do_reset(0, 0, 0, 0);
    wait_busy(n, 500, 0);
    chk("R2 short delay", n, SHORT_DLY);
    chk("R10 hold_pd during por", hold_pd, 1);
    check_phases("por short", 1);
    chk("R10 hold_pd released", hold_pd, 0);
    pwr_down_in = 1'b1;
    @(negedge clk);
    chk("R10 hold_pd follows pd high", hold_pd, 1);
    pwr_down_in = 1'b0;
    @(negedge clk);
    chk("R10 hold_pd follows pd low", hold_pd, 0);
  endtask

  task automatic t_por_long();
    int n;
    do_reset(1, 0, 0, 0);
    wait_busy(n, 500, 0);
    chk("R2 long delay", n, LONG_DLY);
    check_phases("por long", 1);
  endtask

  task automatic t_ext_mode();
    int n;
    do_reset(1, 1, 0, 0);
    wait_busy(n, 500, 0);
    chk("R3 ext mode forces short", n, SHORT_DLY);
    check_phases("ext mode", 1);
  endtask

  task automatic t_pd_freeze();
    int n;
    do_reset(0, 0, 1, 0);
    wait_busy(n, 500, 7);
    chk("R4 pd freezes settle", n, SHORT_DLY + 7);
    check_phases("pd freeze", 1);
  endtask

  task automatic t_skip_por();
    int n;
    do_reset(0, 0, 0, 1);
    @(negedge clk);
    chk("R6 hold_pd released on skip", hold_pd, 0);
    no_busy_for("R6 no por when req high", SHORT_DLY + TERM_LEN + 20);
    qualified_request(n);
    chk("R6 first cal after low qual", n, HIGH_MIN);
    check_phases("skip then cmd R6", 0);
  endtask

  task automatic t_on_command();
    int n;
    do_reset(0, 0, 0, 0);
    wait_busy(n, 500, 0);
    check_phases("por before cmd", 1);
    repeat (3) @(negedge clk);
    qualified_request(n);
    chk("R7 start after HIGH_MIN", n, HIGH_MIN);
    check_phases("on command R7", 0);
  endtask

  task automatic t_reject();
    cal_req_pin = 1'b0;
    repeat (LOW_MIN - 1) @(negedge clk);
    cal_req_pin = 1'b1;
    no_busy_for("R8 short low rejected", HIGH_MIN + 10);
    cal_req_pin = 1'b0;
    repeat (LOW_MIN) @(negedge clk);
    cal_req_pin = 1'b1;
    repeat (HIGH_MIN - 1) @(negedge clk);
    cal_req_pin = 1'b0;
    @(negedge clk);
    cal_req_pin = 1'b1;
    no_busy_for("R8 short high rejected", HIGH_MIN + 10);
  endtask

  task automatic t_ignore_busy();
    int n;
    qualified_request(n);
    chk("R9 setup request", n, HIGH_MIN);
    cal_req_pin = 1'b0;
    repeat (LOW_MIN) @(negedge clk);
    cal_req_pin = 1'b1;
    for (int i = 0; i < 20 && busy; i++) @(negedge clk);
    chk("R9 busy ended", busy, 0);
    no_busy_for("R9 request during busy ignored", 30);
    repeat (2) @(negedge clk);
    // request during settling has no effect either
    do_reset(0, 0, 0, 0);
    cal_req_pin = 1'b0;
    repeat (LOW_MIN + 1) @(negedge clk);
    cal_req_pin = 1'b1;
    wait_busy(n, 500, 0);
    chk("R9 settle unaffected by request", n + LOW_MIN + 1, SHORT_DLY);
    chk("R9 settle request gives por", cal_phase, 1);
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
    no_busy_for("R9 no extra run after por", 30);
  endtask

  initial begin
    t_reset_state();
    t_por_short();
    t_por_long();
    t_ext_mode();
    t_pd_freeze();
    t_skip_por();
    t_on_command();
    t_reject();
    t_ignore_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule